// File: doc/BRIEF.md
# Configurable Product-Term Logic Array

This block is the programmable AND-OR plane of one logic cluster. Each of the input signals is offered to the array in true and in complemented form. Every product term chooses any set of these literals and ANDs them together. A steering matrix then ORs a selected set of terms into each sum output. One term can feed several sums, so logic shared between outputs is built only once.

All of the configuration sits in a single serial chain. The chain holds one word per product term: the literal enables, followed by that term's connections to the sum outputs. The chain advances by one bit on each configuration clock edge while the load strobe is high. When loading ends, the block counts the terms attached to each sum. Any sum with more terms than the limit is disabled. Array evaluation is purely combinational, and its delay does not depend on how many terms are in use.

Top module: `pterm_array`

## Requirements
- R1: After reset, and before any configuration has been loaded, `sum_o` is all zeros for every value of `in_i`.
- R2: While `cfg_load_i` is high, `sum_o` is zero. It stays zero after `cfg_load_i` falls until the first rising `cfg_clk_i` edge at which `cfg_load_i` is low.
- R3: In term word k, bit 2i enables the true form of `in_i[i]` and bit 2i+1 enables its complement. The term is the AND of all enabled literals.
- R4: A term with no enabled literal evaluates to 1.
- R5: A term that enables both forms of the same input evaluates to 0.
- R6: Bit 72+j of term word k attaches term k to `sum_o[j]`. Each sum is the OR of its attached terms.
- R7: A sum with no attached terms drives 0.
- R8: One term attached to several sums contributes to each of them.
- R9: A sum with up to 16 attached terms works normally, including exactly 16. A sum with 17 or more attached terms is rejected at the end of loading and drives 0, and the other sums are not affected.
- R10: Once configured, `sum_o` follows `in_i` combinationally, with no clock edge in between.
- R11: On each rising `cfg_clk_i` edge with `cfg_load_i` high, the chain shifts by one bit. `cfg_data_i` enters bit 0 of word 0, the top bit of word k moves into bit 0 of word k+1, and the first bit shifted in finally rests in the top bit of word 85. While `cfg_load_i` is low, `cfg_data_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk_i | input | 1 | Configuration clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_load_i | input | 1 | Shift enable for the configuration chain |
| cfg_data_i | input | 1 | Serial configuration bit |
| in_i | input | 36 | Array inputs |
| sum_o | output | 16 | Sum-of-products outputs |

## Verification
The sum outputs are combinational in `in_i`, so each result is due in the same cycle as its stimulus. The bench changes inputs on the falling edge and samples 2 ns later, before any rising edge can occur. The ready flag and the over-limit mask are registered at the first rising edge with the load strobe low. For that reason the bench checks for zeros both during loading and between the strobe's fall and that edge, and it checks the configured behaviour only after that edge. Configuration bits are shifted one per rising edge, and the bench feeds them in the order set by R11.

// File: rtl/pterm_array_pkg.sv
package pterm_array_pkg;
  localparam int unsigned NUM_IN_DEF    = 36;
  localparam int unsigned NUM_PT_DEF    = 86;
  localparam int unsigned NUM_SUM_DEF   = 16;
  localparam int unsigned MAX_TERMS_DEF = 16;
endpackage

// File: rtl/pterm_cfg_chain.sv
module pterm_cfg_chain #(
  parameter int unsigned NUM_PT = 86,
  parameter int unsigned WORD_W = 88
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              data_i,
  output logic [WORD_W-1:0] word_o [NUM_PT]
);
  logic [WORD_W-1:0] word_q [NUM_PT];

  for (genvar k = 0; k < NUM_PT; k++) begin : g_word
    logic feed;
    if (k == 0) begin : g_head
      assign feed = data_i;
    end else begin : g_link
      assign feed = word_q[k-1][WORD_W-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      word_q[k] <= '0;
      else if (shift_i) word_q[k] <= {word_q[k][WORD_W-2:0], feed};
    end
    assign word_o[k] = word_q[k];
  end
endmodule

// File: rtl/pterm_and_plane.sv
module pterm_and_plane #(
  parameter int unsigned NUM_IN = 36,
  parameter int unsigned NUM_PT = 86,
  parameter int unsigned WORD_W = 88,
  localparam int unsigned COLS  = 2 * NUM_IN
) (
  input  logic [NUM_IN-1:0] in_i,
  input  logic [WORD_W-1:0] word_i [NUM_PT],
  output logic [NUM_PT-1:0] pt_o
);
  logic [COLS-1:0] lit;

  for (genvar i = 0; i < NUM_IN; i++) begin : g_lit
    assign lit[2*i]   = in_i[i];
    assign lit[2*i+1] = ~in_i[i];
  end

  // disabled columns read as 1, so an empty term is 1
  for (genvar k = 0; k < NUM_PT; k++) begin : g_term
    assign pt_o[k] = &(~word_i[k][COLS-1:0] | lit);
  end
endmodule

// File: rtl/pterm_or_alloc.sv
module pterm_or_alloc #(
  parameter int unsigned NUM_PT    = 86,
  parameter int unsigned NUM_SUM   = 16,
  parameter int unsigned COLS      = 72,
  parameter int unsigned WORD_W    = 88,
  parameter int unsigned MAX_TERMS = 16,
  localparam int unsigned CNT_W    = $clog2(NUM_PT + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               capture_i,
  input  logic [NUM_PT-1:0]  pt_i,
  input  logic [WORD_W-1:0]  word_i [NUM_PT],
  output logic [NUM_SUM-1:0] sum_o
);
  logic [NUM_SUM-1:0] ok_d, ok_q;

  for (genvar j = 0; j < NUM_SUM; j++) begin : g_sum
    logic [NUM_PT-1:0] col;
    logic [CNT_W-1:0]  cnt;
    for (genvar k = 0; k < NUM_PT; k++) begin : g_col
      assign col[k] = word_i[k][COLS+j];
    end
    always_comb begin
      cnt = '0;
      for (int k = 0; k < NUM_PT; k++) cnt = cnt + CNT_W'(col[k]);
    end
    assign ok_d[j]  = (cnt <= CNT_W'(MAX_TERMS));
    assign sum_o[j] = ok_q[j] & |(pt_i & col);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ok_q <= '0;
    else if (capture_i) ok_q <= ok_d;
  end
endmodule

// File: rtl/pterm_array.sv
module pterm_array
  import pterm_array_pkg::*;
#(
  parameter int unsigned NUM_IN    = NUM_IN_DEF,
  parameter int unsigned NUM_PT    = NUM_PT_DEF,
  parameter int unsigned NUM_SUM   = NUM_SUM_DEF,
  parameter int unsigned MAX_TERMS = MAX_TERMS_DEF
) (
  input  logic               cfg_clk_i,
  input  logic               rst_ni,
  input  logic               cfg_load_i,
  input  logic               cfg_data_i,
  input  logic [NUM_IN-1:0]  in_i,
  output logic [NUM_SUM-1:0] sum_o
);
  localparam int unsigned COLS   = 2 * NUM_IN;
  localparam int unsigned WORD_W = COLS + NUM_SUM;

  logic [WORD_W-1:0]  cfg_words [NUM_PT];
  logic [NUM_PT-1:0]  pt;
  logic [NUM_SUM-1:0] sum_raw;
  logic               loading_q, ready_q, capture;

  pterm_cfg_chain #(.NUM_PT(NUM_PT), .WORD_W(WORD_W)) u_chain (
    .clk_i(cfg_clk_i), .rst_ni(rst_ni), .shift_i(cfg_load_i),
    .data_i(cfg_data_i), .word_o(cfg_words)
  );

  pterm_and_plane #(.NUM_IN(NUM_IN), .NUM_PT(NUM_PT), .WORD_W(WORD_W)) u_and (
    .in_i(in_i), .word_i(cfg_words), .pt_o(pt)
  );

  assign capture = loading_q & ~cfg_load_i;

  pterm_or_alloc #(
    .NUM_PT(NUM_PT), .NUM_SUM(NUM_SUM), .COLS(COLS),
    .WORD_W(WORD_W), .MAX_TERMS(MAX_TERMS)
  ) u_or (
    .clk_i(cfg_clk_i), .rst_ni(rst_ni), .capture_i(capture),
    .pt_i(pt), .word_i(cfg_words), .sum_o(sum_raw)
  );

  always_ff @(posedge cfg_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      loading_q <= 1'b0;
      ready_q   <= 1'b0;
    end else begin
      loading_q <= cfg_load_i;
      if (cfg_load_i)     ready_q <= 1'b0;
      else if (loading_q) ready_q <= 1'b1;
    end
  end

  assign sum_o = (ready_q && !cfg_load_i) ? sum_raw : '0;
endmodule

// File: rtl/pterm_array_chk.sv
module pterm_array_chk #(
  parameter int unsigned NUM_PT    = 86,
  parameter int unsigned NUM_SUM   = 16,
  parameter int unsigned COLS      = 72,
  parameter int unsigned WORD_W    = 88,
  parameter int unsigned MAX_TERMS = 16,
  localparam int unsigned CNT_W    = $clog2(NUM_PT + 1)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               load_i,
  input logic [NUM_SUM-1:0] sum_i,
  input logic [WORD_W-1:0]  cfg_i [NUM_PT]
);
  logic [NUM_PT*WORD_W-1:0] flat;
  for (genvar k = 0; k < NUM_PT; k++) begin : g_flat
    assign flat[k*WORD_W +: WORD_W] = cfg_i[k];
  end

  // R2
  load_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (sum_i == '0));

  // R2
  load_end_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(load_i) |-> (sum_i == '0));

  // R11
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(flat));

  for (genvar j = 0; j < NUM_SUM; j++) begin : g_out
    logic [CNT_W-1:0] n;
    always_comb begin
      n = '0;
      for (int k = 0; k < NUM_PT; k++) n = n + CNT_W'(cfg_i[k][COLS+j]);
    end
    // R7
    empty_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (n == '0) |-> !sum_i[j]);
    // R9
    over_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!load_i && n > CNT_W'(MAX_TERMS)) |-> !sum_i[j]);
  end
endmodule

bind pterm_array pterm_array_chk #(
  .NUM_PT(NUM_PT), .NUM_SUM(NUM_SUM), .COLS(COLS),
  .WORD_W(WORD_W), .MAX_TERMS(MAX_TERMS)
) u_chk (
  .clk_i(cfg_clk_i), .rst_ni(rst_ni), .load_i(cfg_load_i),
  .sum_i(sum_o), .cfg_i(cfg_words)
);

// File: tb/pterm_array_tb.sv
`timescale 1ns/1ps
module pterm_array_tb;
  localparam int NI = 36, NP = 86, NS = 16, MAXT = 16, CL = 72, WW = 88;

  logic clk = 1'b0, rst_n = 1'b0, load = 1'b0, data = 1'b0;
  logic [NI-1:0] x = '0;
  logic [NS-1:0] sum;
  logic [WW-1:0] cfg [NP];
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  pterm_array u_dut (
    .cfg_clk_i(clk), .rst_ni(rst_n), .cfg_load_i(load),
    .cfg_data_i(data), .in_i(x), .sum_o(sum)
  );

  task automatic check(input string tag, input logic [NS-1:0] got, input logic [NS-1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [NS-1:0] model(input logic [NI-1:0] v);
    logic [NP-1:0] t;
    logic [NS-1:0] r;
    for (int k = 0; k < NP; k++) begin
      t[k] = 1'b1;
      for (int i = 0; i < NI; i++) begin
        if (cfg[k][2*i] && !v[i]) t[k] = 1'b0;
        if (cfg[k][2*i+1] && v[i]) t[k] = 1'b0;
      end
    end
    for (int j = 0; j < NS; j++) begin
      int c = 0;
      r[j] = 1'b0;
      for (int k = 0; k < NP; k++) if (cfg[k][CL+j]) begin c++; r[j] |= t[k]; end
      if (c > MAXT) r[j] = 1'b0;
    end
    return r;
  endfunction

  // R11 order: word NP-1 top bit first, word 0 bit 0 last
  task automatic load_cfg();
    @(negedge clk);
    load = 1'b1;
    for (int k = NP - 1; k >= 0; k--) begin
      for (int b = WW - 1; b >= 0; b--) begin
        data = cfg[k][b];
        if (k == NP / 2 && b == 0) begin
          #2 check("R2 mid-load", sum, '0);
        end
        @(negedge clk);
      end
    end
    load = 1'b0;
    x = x ^ {NI{1'b1}};
    #2 check("R2 before ready edge", sum, '0);
    @(negedge clk);
  endtask

  task automatic apply(input logic [NI-1:0] v, input string tag);
    @(negedge clk);
    x = v;
    #2 check(tag, sum, model(v));
  endtask

  task automatic rand_cfg(input int en_div, input int conn_div);
    for (int k = 0; k < NP; k++)
      for (int b = 0; b < WW; b++)
        cfg[k][b] = (b < CL) ? ($urandom % en_div == 0) : ($urandom % conn_div == 0);
  endtask

  function automatic logic [NI-1:0] rnd_in();
    return {$urandom, $urandom};
  endfunction

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [NI-1:0] v;
    void'($urandom(32'd4242));
    #45 rst_n = 1'b1;
    for (int n = 0; n < 4; n++) begin
      @(negedge clk); x = rnd_in();
      #2 check("R1 reset state", sum, '0);
    end

    // configuration A: directed corners plus random sums 7..15
    for (int k = 0; k < NP; k++) cfg[k] = '0;
    cfg[0][CL+0] = 1'b1;                                   // R4 empty term
    cfg[1][6] = 1'b1; cfg[1][7] = 1'b1; cfg[1][CL+1] = 1'b1; // R5
    cfg[2][0] = 1'b1; cfg[2][3] = 1'b1;                    // R3 in0 & ~in1
    cfg[2][CL+3] = 1'b1; cfg[2][CL+4] = 1'b1;              // R8 shared
    for (int k = 10; k < 26; k++) begin cfg[k][2*(k-10)] = 1'b1; cfg[k][CL+5] = 1'b1; end
    for (int k = 30; k < 47; k++) cfg[k][CL+6] = 1'b1;     // 17 terms
    for (int k = 50; k < NP; k++) begin
      for (int b = 0; b < CL; b++) cfg[k][b] = ($urandom % 20 == 0);
      for (int j = 7; j < NS; j++) cfg[k][CL+j] = ($urandom % 6 == 0);
    end
    load_cfg();

    for (int n = 0; n < 24; n++) begin
      v = (n == 0) ? '0 : (n == 1) ? NI'(1) << 15 : (n == 2) ? NI'(1) : rnd_in();
      @(negedge clk); x = v;
      #2;
      check("R4 empty term", {15'd0, sum[0]}, 16'd1);
      check("R5 both polarities", {15'd0, sum[1]}, 16'd0);
      check("R7 no terms", {15'd0, sum[2]}, 16'd0);
      check("R3 literal select", {15'd0, sum[3]}, {15'd0, v[0] & ~v[1]});
      check("R8 shared term", {15'd0, sum[4]}, {15'd0, v[0] & ~v[1]});
      check("R9 sixteen terms", {15'd0, sum[5]}, {15'd0, |v[15:0]});
      check("R9 seventeen rejected", {15'd0, sum[6]}, 16'd0);
      check("R6 full sums", sum, model(v));
    end

    // R11: data toggling with load low leaves configuration intact
    for (int n = 0; n < 20; n++) begin @(negedge clk); data = $urandom; end
    for (int n = 0; n < 8; n++) apply(rnd_in(), "R11 idle data ignored");

    // R10: change inputs twice between edges, no clock edge between
    for (int n = 0; n < 8; n++) begin
      @(negedge clk);
      v = rnd_in(); x = v;
      #1 check("R10 combinational", sum, model(v));
      v = ~v; x = v;
      #1 check("R10 combinational", sum, model(v));
    end

    // configuration B: random sparse
    rand_cfg(24, 12);
    load_cfg();
    for (int n = 0; n < 40; n++) apply(rnd_in(), "R6 random config");

    // configuration C: dense steering, many sums over the limit
    rand_cfg(40, 4);
    cfg[3][CL+15] = 1'b1;
    load_cfg();
    for (int n = 0; n < 40; n++) apply(rnd_in(), "R9 dense config");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule